// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Timing Unit

This block drives the gates of a three-phase bridge. Each phase has a high-side and a low-side output. One period is made of two halves. The high-side pulse is centred on the middle of the period and the low-side pulse is centred on the period boundary. Dead time separates every high-to-low and low-to-high hand-over. A sync pulse marks each period start, and a status bit reports which half is running.

Software programs the unit through a plain register write strobe. Every write goes into a shadow copy. The copy reaches the working registers only at a reload point. In single update mode the only reload point is the period start, so both halves use the same values. In double update mode the midpoint is also a reload point, so the two halves may differ in length, duty and dead time. The write port has no back-pressure: a write is taken on every cycle where `wr_en` is high. The gate outputs stay low until the period register and all three duty registers have each been written once.

Top module: `pwm3_unit`

## Requirements
- R1: Reset drives all six gate outputs and `sync_out` low. They stay low until the period register and all three duty registers have each been written at least once, and no PWM cycle starts before that.
- R2: In single update mode, with half length P, duty D and dead time T, the high side is on for 2·clamp(D−T, 0, P) cycles per period. The low side is on for 2·max(P−D−T, 0) cycles per period.
- R3: A period lasts 2·P cycles in single update mode. In double update mode it lasts P1+P2 cycles, where P1 and P2 are the half lengths in force for the first and second half.
- R4: `sync_out` rises on the first cycle of each period and stays high for min(S+1, P1) cycles, where S is the sync-width register.
- R5: `half_stat` is 0 during the first half of each period and 1 during the second half. It is high for P2 cycles per period.
- R6: In double update mode, each half adds its own share to the on-times. The high side gets clamp(D−T, 0, P) cycles per half and the low side gets max(P−D−T, 0) cycles per half, using that half's values.
- R7: A register write never changes the period in progress. In single update mode it takes effect at the next period start. In double update mode it takes effect at the next period start or midpoint, whichever comes first.
- R8: The high-side and low-side outputs of a phase are never high in the same cycle.
- R9: The first write to the period register (value P) starts the timer. If the duty registers follow before the first boundary, the first sync pulse starts 2·P−floor(P/2) cycles after that write in single update mode (1.5·P for even P). In double update mode it starts P cycles after the write.
- R10: Register addresses on `wr_addr`: 0 = half-period length, 1/2/3 = duty for phases 0/1/2, 4 = dead time, 5 = sync width. Bit i of `gate_hi` and `gate_lo` belongs to phase i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dbl_mode | input | 1 | 1 = reload at period start and midpoint, 0 = reload at period start only |
| wr_en | input | 1 | Register write strobe, taken on every cycle where it is high |
| wr_addr | input | 3 | Register address (see R10) |
| wr_data | input | CW | Register write value |
| gate_hi | output | NPH | High-side gate drive, one bit per phase |
| gate_lo | output | NPH | Low-side gate drive, one bit per phase |
| sync_out | output | 1 | Pulse at the start of each period |
| half_stat | output | 1 | 0 = first half, 1 = second half |

## Verification
The on-times are measured over whole periods. In single update mode the stimulus is random half lengths, duties, dead times and sync widths. This exposes faults that matter only when the dead time is non-zero or when a duty is clipped at either end. Directed corners put one duty below the dead time, one above the half length plus the dead time, and one at zero, which tests the 0% and 100% clamps. Double update runs write different values before and after each midpoint. This separates the midpoint reload from the period-start reload and shows a swap of the two halves' shares. Start-up runs withhold one duty register to check that the output stays disabled, and they time the first sync pulse in each mode.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  // Register addresses; duty registers of phase i sit at ADDR_DUTY0 + i
  localparam int ADDR_PERIOD = 0;
  localparam int ADDR_DUTY0  = 1;
  localparam int ADDR_DEAD   = 4;
  localparam int ADDR_SYNC   = 5;
  localparam int ADDR_W      = 3;
endpackage

// File: rtl/pwm3_shadow.sv
module pwm3_shadow #(
  parameter int CW  = 10,
  parameter int NPH = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [2:0]               wr_addr,
  input  logic [CW-1:0]            wr_data,
  output logic [CW-1:0]            sh_per,
  output logic [CW-1:0]            sh_dead,
  output logic [CW-1:0]            sh_sync,
  output logic [NPH-1:0][CW-1:0]   sh_duty,
  output logic                     all_set,
  output logic                     per_first
);
  import pwm3_pkg::*;

  logic           per_seen;
  logic [NPH-1:0] duty_seen;

  wire hit_per  = wr_en && (wr_addr == ADDR_W'(ADDR_PERIOD));
  wire hit_dead = wr_en && (wr_addr == ADDR_W'(ADDR_DEAD));
  wire hit_sync = wr_en && (wr_addr == ADDR_W'(ADDR_SYNC));

  assign per_first = hit_per && !per_seen;
  assign all_set   = per_seen && (&duty_seen);

  always_ff @(posedge clk) begin
    if (rst) begin
      per_seen <= 1'b0;
      sh_per   <= '0;
      sh_dead  <= '0;
      sh_sync  <= '0;
    end else begin
      if (hit_per) begin
        sh_per   <= wr_data;
        per_seen <= 1'b1;
      end
      if (hit_dead) sh_dead <= wr_data;
      if (hit_sync) sh_sync <= wr_data;
    end
  end

  for (genvar i = 0; i < NPH; i++) begin : g_duty
    wire hit_duty = wr_en && (wr_addr == ADDR_W'(ADDR_DUTY0 + i));
    always_ff @(posedge clk) begin
      if (rst) begin
        sh_duty[i]   <= '0;
        duty_seen[i] <= 1'b0;
      end else if (hit_duty) begin
        sh_duty[i]   <= wr_data;
        duty_seen[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm3_timer.sv
module pwm3_timer #(
  parameter int CW  = 10,
  parameter int NPH = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     dbl_mode,
  input  logic                     per_first,
  input  logic [CW-1:0]            wr_data,
  input  logic                     all_set,
  input  logic [CW-1:0]            sh_per,
  input  logic [CW-1:0]            sh_dead,
  input  logic [CW-1:0]            sh_sync,
  input  logic [NPH-1:0][CW-1:0]   sh_duty,
  output logic [CW-1:0]            cnt,
  output logic                     half,
  output logic                     run,
  output logic [CW-1:0]            act_per,
  output logic [CW-1:0]            act_dead,
  output logic [CW-1:0]            act_sync,
  output logic [NPH-1:0][CW-1:0]   act_duty
);
  logic          started;
  logic [CW:0]   cnt_nx;
  logic          wrap;

  assign cnt_nx = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
  assign wrap   = started && (cnt_nx >= {1'b0, act_per});

  always_ff @(posedge clk) begin
    if (rst) begin
      started  <= 1'b0;
      run      <= 1'b0;
      cnt      <= '0;
      half     <= 1'b0;
      act_per  <= '0;
      act_dead <= '0;
      act_sync <= '0;
      act_duty <= '0;
    end else if (per_first) begin
      // single: start mid first half; double: start at the midpoint
      started <= 1'b1;
      act_per <= wr_data;
      half    <= dbl_mode;
      cnt     <= dbl_mode ? '0 : (wr_data >> 1);
    end else if (started) begin
      if (wrap) begin
        cnt  <= '0;
        half <= ~half;
        if (half || dbl_mode) begin
          act_per  <= sh_per;
          act_dead <= sh_dead;
          act_sync <= sh_sync;
          act_duty <= sh_duty;
        end
        if (half && all_set) run <= 1'b1;
      end else begin
        cnt <= cnt_nx[CW-1:0];
      end
    end
  end
endmodule

// File: rtl/pwm3_leg.sv
module pwm3_leg #(
  parameter int CW = 10
) (
  input  logic [CW-1:0] cnt,
  input  logic          half,
  input  logic          run,
  input  logic [CW-1:0] per,
  input  logic [CW-1:0] dead,
  input  logic [CW-1:0] duty,
  output logic          hi,
  output logic          lo
);
  logic [CW:0] d_x, t_x, p_x, c_x, diff, sum, hi_len, lo_len;

  always_comb begin
    d_x    = {1'b0, duty};
    t_x    = {1'b0, dead};
    p_x    = {1'b0, per};
    c_x    = {1'b0, cnt};
    diff   = d_x - t_x;
    sum    = d_x + t_x;
    hi_len = (d_x > t_x) ? ((diff > p_x) ? p_x : diff) : '0;
    lo_len = (p_x > sum) ? (p_x - sum) : '0;
    if (!run) begin
      hi = 1'b0;
      lo = 1'b0;
    end else if (!half) begin
      // first half: low side at the start, high side at the end
      hi = (c_x >= p_x - hi_len);
      lo = (c_x < lo_len);
    end else begin
      hi = (c_x < hi_len);
      lo = (c_x >= p_x - lo_len);
    end
  end
endmodule

// File: rtl/pwm3_unit.sv
module pwm3_unit #(
  parameter int CW  = 10,
  parameter int NPH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           dbl_mode,
  input  logic           wr_en,
  input  logic [2:0]     wr_addr,
  input  logic [CW-1:0]  wr_data,
  output logic [NPH-1:0] gate_hi,
  output logic [NPH-1:0] gate_lo,
  output logic           sync_out,
  output logic           half_stat
);
  logic [CW-1:0]           sh_per, sh_dead, sh_sync;
  logic [NPH-1:0][CW-1:0]  sh_duty;
  logic                    all_set, per_first;
  logic [CW-1:0]           cnt, act_per, act_dead, act_sync;
  logic [NPH-1:0][CW-1:0]  act_duty;
  logic                    half, run;

  pwm3_shadow #(.CW(CW), .NPH(NPH)) u_shadow (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sh_per(sh_per), .sh_dead(sh_dead), .sh_sync(sh_sync), .sh_duty(sh_duty),
    .all_set(all_set), .per_first(per_first)
  );

  pwm3_timer #(.CW(CW), .NPH(NPH)) u_timer (
    .clk(clk), .rst(rst), .dbl_mode(dbl_mode), .per_first(per_first),
    .wr_data(wr_data), .all_set(all_set),
    .sh_per(sh_per), .sh_dead(sh_dead), .sh_sync(sh_sync), .sh_duty(sh_duty),
    .cnt(cnt), .half(half), .run(run),
    .act_per(act_per), .act_dead(act_dead), .act_sync(act_sync), .act_duty(act_duty)
  );

  for (genvar i = 0; i < NPH; i++) begin : g_leg
    pwm3_leg #(.CW(CW)) u_leg (
      .cnt(cnt), .half(half), .run(run), .per(act_per), .dead(act_dead),
      .duty(act_duty[i]), .hi(gate_hi[i]), .lo(gate_lo[i])
    );
  end

  assign sync_out  = run && !half && (cnt <= act_sync);
  assign half_stat = half;
endmodule

// File: rtl/pwm3_unit_chk.sv
module pwm3_unit_chk #(
  parameter int NPH = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_en,
  input logic [2:0]     wr_addr,
  input logic [NPH-1:0] gate_hi,
  input logic [NPH-1:0] gate_lo,
  input logic           sync_out,
  input logic           half_stat
);
  import pwm3_pkg::*;

  logic           seen_per;
  logic [NPH-1:0] seen_duty;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_per  <= 1'b0;
      seen_duty <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(ADDR_PERIOD)) seen_per <= 1'b1;
      for (int i = 0; i < NPH; i++)
        if (wr_addr == ADDR_W'(ADDR_DUTY0 + i)) seen_duty[i] <= 1'b1;
    end
  end

  // R8
  no_shoot_through_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_hi & gate_lo) == '0);

  // R1
  quiet_until_armed_chk: assert property (@(posedge clk) disable iff (rst)
    !(seen_per && (&seen_duty)) |-> (gate_hi == '0 && gate_lo == '0 && !sync_out));

  // R4
  sync_first_half_chk: assert property (@(posedge clk) disable iff (rst)
    sync_out |-> !half_stat);

  // R3
  sync_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_out) |-> $past(half_stat));
endmodule

bind pwm3_unit pwm3_unit_chk #(.NPH(NPH)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .gate_hi(gate_hi), .gate_lo(gate_lo), .sync_out(sync_out), .half_stat(half_stat)
);

// File: tb/pwm3_unit_bench.sv
module pwm3_unit_bench;
  localparam int CW  = 10;
  localparam int NPH = 3;

  typedef struct { int p; int d0; int d1; int d2; int dt; int sw; } cfg_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           dbl_mode = 1'b0;
  logic           wr_en = 1'b0;
  logic [2:0]     wr_addr = '0;
  logic [CW-1:0]  wr_data = '0;
  logic [NPH-1:0] gate_hi, gate_lo;
  logic           sync_out, half_stat;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int m_len, m_sync, m_stat;
  int m_hi[NPH];
  int m_lo[NPH];

  always #5 clk = ~clk;

  pwm3_unit #(.CW(CW), .NPH(NPH)) u_pwm3_unit (
    .clk(clk), .rst(rst), .dbl_mode(dbl_mode), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .gate_hi(gate_hi), .gate_lo(gate_lo),
    .sync_out(sync_out), .half_stat(half_stat)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int hlen(int d, int dt, int p);
    int v = d - dt;
    if (v < 0) v = 0;
    if (v > p) v = p;
    return v;
  endfunction

  function automatic int llen(int d, int dt, int p);
    int v = p - d - dt;
    return (v < 0) ? 0 : v;
  endfunction

  function automatic int dsel(cfg_t c, int i);
    return (i == 0) ? c.d0 : (i == 1) ? c.d1 : c.d2;
  endfunction

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  function automatic cfg_t pick();
    cfg_t c;
    c.p  = 16 + int'($urandom % 45);
    c.d0 = int'($urandom % 32'(c.p + 10));
    c.d1 = int'($urandom % 32'(c.p + 10));
    c.d2 = int'($urandom % 32'(c.p + 10));
    c.dt = int'($urandom % 7);
    c.sw = int'($urandom % 32'(c.p + 3));
    return c;
  endfunction

  task automatic wr(input int a, input int v);
    wr_en   = 1'b1;
    wr_addr = 3'(a);
    wr_data = CW'(v);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // R10 address map
  task automatic put(input cfg_t c);
    wr(0, c.p); wr(1, c.d0); wr(2, c.d1); wr(3, c.d2); wr(4, c.dt); wr(5, c.sw);
  endtask

  task automatic wait_sync_rise();
    bit last = sync_out;
    forever begin
      @(negedge clk);
      if (sync_out && !last) break;
      last = sync_out;
    end
  endtask

  task automatic wait_half_rise();
    bit last = half_stat;
    forever begin
      @(negedge clk);
      if (half_stat && !last) break;
      last = half_stat;
    end
  endtask

  // Called on the sample where sync has just risen; returns on the next rise.
  task automatic measure();
    bit last, in_sync;
    m_len = 0; m_sync = 0; m_stat = 0;
    for (int i = 0; i < NPH; i++) begin m_hi[i] = 0; m_lo[i] = 0; end
    in_sync = 1'b1;
    forever begin
      m_len++;
      if (sync_out && in_sync) m_sync++; else in_sync = 1'b0;
      if (half_stat) m_stat++;
      for (int i = 0; i < NPH; i++) begin
        if (gate_hi[i]) m_hi[i]++;
        if (gate_lo[i]) m_lo[i]++;
      end
      last = sync_out;
      @(negedge clk);
      if ((sync_out && !last) || m_len > 4000) break;
    end
  endtask

  task automatic chk_single(input cfg_t c);
    chk("R3 single period length", m_len, 2 * c.p);
    chk("R4 sync width", m_sync, imin(c.sw + 1, c.p));
    chk("R5 status high cycles", m_stat, c.p);
    for (int i = 0; i < NPH; i++) begin
      chk($sformatf("R2 phase %0d high on-time", i), m_hi[i], 2 * hlen(dsel(c, i), c.dt, c.p));
      chk($sformatf("R2 phase %0d low on-time", i), m_lo[i], 2 * llen(dsel(c, i), c.dt, c.p));
    end
  endtask

  task automatic chk_double(input cfg_t a, input cfg_t b);
    chk("R3 double period length", m_len, a.p + b.p);
    chk("R4 double sync width", m_sync, imin(a.sw + 1, a.p));
    chk("R5 double status high cycles", m_stat, b.p);
    for (int i = 0; i < NPH; i++) begin
      chk($sformatf("R6 phase %0d high on-time", i), m_hi[i],
          hlen(dsel(a, i), a.dt, a.p) + hlen(dsel(b, i), b.dt, b.p));
      chk($sformatf("R6 phase %0d low on-time", i), m_lo[i],
          llen(dsel(a, i), a.dt, a.p) + llen(dsel(b, i), b.dt, b.p));
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic startup_time(input bit dbl, input int p, input int exp);
    int c = 0;
    dbl_mode = dbl;
    do_reset();
    wr(0, p);
    fork
      begin
        while (!sync_out && c < 5000) begin @(negedge clk); c++; end
      end
      begin wr(1, p / 2); wr(2, p / 3); wr(3, p / 4); wr(4, 2); wr(5, 1); end
    join
    chk(dbl ? "R9 first sync delay double" : "R9 first sync delay single", c, exp);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    cfg_t cur, nxt, h1, h2, nh1;
    int busy, seed;
    seed = int'($urandom(32'd20240611));

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 reset gate_hi", int'(gate_hi), 0);
    chk("R1 reset gate_lo", int'(gate_lo), 0);
    chk("R1 reset sync", int'(sync_out), 0);
    rst = 1'b0;

    // R1: one duty register withheld keeps everything low
    wr(0, 40); wr(1, 30); wr(2, 20); wr(4, 3); wr(5, 4);
    busy = 0;
    repeat (300) begin
      @(negedge clk);
      if (gate_hi != '0 || gate_lo != '0 || sync_out) busy++;
    end
    chk("R1 outputs low while a duty is unwritten", busy, 0);
    wr(3, 10);
    cur = '{p: 40, d0: 30, d1: 20, d2: 10, dt: 3, sw: 4};
    wait_sync_rise();
    measure();
    chk_single(cur);

    // Single update: writes during a period only apply to the next (R7)
    for (int it = 0; it < 8; it++) begin
      nxt = pick();
      if (it == 0) begin
        nxt.dt = 4; nxt.d0 = 2; nxt.d1 = nxt.p + 9; nxt.d2 = 0;
      end
      if (it == 1) nxt.sw = nxt.p + 1;
      fork
        measure();
        put(nxt);
      join
      chk_single(cur);   // R7: period in progress kept old values
      cur = nxt;
    end

    // Double update: second-half values written after start, next first half after midpoint
    dbl_mode = 1'b1;
    h1 = cur;
    for (int it = 0; it < 8; it++) begin
      h2  = pick();
      nh1 = pick();
      if (it == 0) begin h2.d0 = 1; h2.dt = 5; h2.d1 = h2.p + 8; end
      fork
        measure();
        begin put(h2); wait_half_rise(); put(nh1); end
      join
      chk_double(h1, h2);  // R7: midpoint reload in double mode
      h1 = nh1;
    end

    // R9 start-up timing in both modes
    startup_time(1'b0, 40, 60);
    startup_time(1'b1, 40, 40);
    startup_time(1'b0, 30, 45);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule